// File: doc/BRIEF.md
# Stack Arithmetic Engine

This block is a small zero-address datapath. Operands live in an internal last-in first-out register file, not in named registers. A command either pushes an immediate word or pops the top word to the output. It can also add or multiply the two top entries and leave the single result on top. A sequence such as push A, push B, add, push C, push D, add, multiply, pop therefore evaluates (A+B)·(C+D) with no operand addressing at all.

Commands arrive on a valid/ready port. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the engine is idle, so a producer holds its command and data stable until it sees ready. The engine executes on the following edge. It then returns one `done` pulse with a pass/fail `status` bit and `res_data`. The result side has no back-pressure: `done` lasts exactly one cycle, and `res_data` holds its value until the next command completes.

The pointer holds the number of stored entries, which starts at the empty position of zero. A push first moves the pointer up and writes at the new top. A pop first reads the top and then moves the pointer down. Every command checks the pointer before it touches storage. If the command would break the stack, it leaves the stack untouched and reports failure.

Top module: `stk_calc`

## Requirements
- R1: Entries leave the stack in the reverse of the order they entered: the latest accepted push is the first one returned by a pop.
- R2: A push with fewer than DEPTH entries stored writes `cmd_data` as the new top, raises the level by one, and reports `status`=0 with `res_data` equal to the pushed word.
- R3: A push with DEPTH entries already stored reports `status`=1 and `res_data`=0 and changes no entry; later pops return the earlier contents intact.
- R4: A pop with at least one entry returns the top word on `res_data` with `status`=0 and lowers the level by one.
- R5: A pop on an empty stack reports `status`=1 and `res_data`=0, and the stack stays empty.
- R6: An add with at least two entries removes both top entries and pushes their sum modulo 2^W; `res_data` shows that sum and `status`=0.
- R7: A multiply with at least two entries removes both top entries and pushes the low W bits of their product; `res_data` shows it and `status`=0.
- R8: An add or multiply with fewer than two entries reports `status`=1 and `res_data`=0 and leaves every entry and the level unchanged.
- R9: `cmd_op` encodes 0 = push, 1 = pop, 2 = add, 3 = multiply. `cmd_ready` is low in the cycle after acceptance. Exactly one `done` pulse, one cycle wide, follows each accepted command, high in the cycle after the edge that follows the accepting edge.
- R10: After reset the stack is empty, `cmd_ready`=1, and `done`, `status` and `res_data` are 0.
- R11: The sequence push A, push B, add, push C, push D, add, multiply, pop returns (A+B)·(C+D) truncated to W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 2 | Command code (0 push, 1 pop, 2 add, 3 multiply) |
| cmd_data | input | W | Immediate word for a push |
| res_data | output | W | Popped or computed word, 0 on failure |
| done | output | 1 | One-cycle completion pulse |
| status | output | 1 | 0 pass, 1 underflow or overflow |

## Verification
The bench builds the engine with W=16 and DEPTH=4. The shallow depth lets a few pushes reach the full boundary, so the refused push and the full drain in reverse order come within a short run. The 16-bit width keeps the wrap of a sum past 0xFFFF and the truncation of a product above 65535 easy to set up with small operands.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_ADD  = 2'd2,
    OP_MUL  = 2'd3
  } stk_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } stk_state_e;
endpackage

// File: rtl/stk_store.sv
module stk_store #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_idx_a,
  input  logic [AW-1:0] rd_idx_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= '0;
      else if (wr_en && (wr_idx == AW'(g)))        q <= wr_data;
    end
    assign slots[g] = q;
  end

  assign rd_a = slots[rd_idx_a];
  assign rd_b = slots[rd_idx_b];
endmodule

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int W = 16
) (
  input  logic         mul_sel,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] y
);
  logic [W-1:0]   sum;
  logic [2*W-1:0] prod;

  assign sum  = lhs + rhs;
  assign prod = {{W{1'b0}}, lhs} * {{W{1'b0}}, rhs};
  assign y    = mul_sel ? prod[W-1:0] : sum;
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [W-1:0]  cmd_data,
  input  logic [W-1:0]  top_val,
  input  logic [W-1:0]  alu_y,
  output logic [AW-1:0] top_idx,
  output logic [AW-1:0] next_idx,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic [W-1:0]  wr_data,
  output logic          mul_sel,
  output logic [W-1:0]  res_data,
  output logic          done,
  output logic          status,
  output logic [CW-1:0] level
);
  stk_state_e    state;
  stk_op_e       op_q;
  logic [W-1:0]  data_q;
  logic [CW-1:0] cnt, nxt_cnt;
  logic          fail;
  logic [W-1:0]  out_val;

  assign cmd_ready = (state == ST_IDLE);
  assign level     = cnt;
  assign top_idx   = AW'(cnt - CW'(1));
  assign next_idx  = AW'(cnt - CW'(2));
  assign mul_sel   = (op_q == OP_MUL);

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = '0;
    wr_data = data_q;
    fail    = 1'b0;
    nxt_cnt = cnt;
    out_val = '0;
    if (state == ST_EXEC) begin
      case (op_q)
        OP_PUSH: begin
          if (cnt == CW'(DEPTH)) fail = 1'b1;
          else begin
            wr_en   = 1'b1;
            wr_idx  = AW'(cnt);
            wr_data = data_q;
            nxt_cnt = cnt + CW'(1);
            out_val = data_q;
          end
        end
        OP_POP: begin
          if (cnt == '0) fail = 1'b1;
          else begin
            out_val = top_val;
            nxt_cnt = cnt - CW'(1);
          end
        end
        default: begin
          if (cnt < CW'(2)) fail = 1'b1;
          else begin
            wr_en   = 1'b1;
            wr_idx  = next_idx;
            wr_data = alu_y;
            nxt_cnt = cnt - CW'(1);
            out_val = alu_y;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_q     <= OP_PUSH;
      data_q   <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      status   <= 1'b0;
      res_data <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          op_q   <= stk_op_e'(cmd_op);
          data_q <= cmd_data;
          state  <= ST_EXEC;
        end
        default: begin
          state    <= ST_IDLE;
          cnt      <= nxt_cnt;
          done     <= 1'b1;
          status   <= fail;
          res_data <= out_val;
        end
      endcase
    end
  end
endmodule

// File: rtl/stk_calc.sv
module stk_calc #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [1:0]   cmd_op,
  input  logic [W-1:0] cmd_data,
  output logic [W-1:0] res_data,
  output logic         done,
  output logic         status
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] top_idx, next_idx, wr_idx;
  logic          wr_en, mul_sel;
  logic [W-1:0]  wr_data, top_val, next_val, alu_y;
  logic [CW-1:0] level;

  stk_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_a(top_idx), .rd_idx_b(next_idx), .rd_a(top_val), .rd_b(next_val)
  );

  stk_alu #(.W(W)) u_alu (
    .mul_sel(mul_sel), .lhs(next_val), .rhs(top_val), .y(alu_y)
  );

  stk_ctrl #(.W(W), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .top_val(top_val), .alu_y(alu_y),
    .top_idx(top_idx), .next_idx(next_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .mul_sel(mul_sel), .res_data(res_data), .done(done),
    .status(status), .level(level)
  );
endmodule

// File: rtl/stk_calc_chk.sv
module stk_calc_chk #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic          done,
  input logic          status,
  input logic [W-1:0]  res_data,
  input logic [CW-1:0] level
);
  logic [1:0] last_op;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      last_op <= 2'd0;
    else if (cmd_valid && cmd_ready) last_op <= cmd_op;
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_ready ##1 done));
  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status) |-> (level == $past(level) && res_data == '0));
  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !status && last_op == 2'd0) |-> level == $past(level) + CW'(1));
  // R4
  shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !status && last_op != 2'd0) |-> level == $past(level) - CW'(1));
  // R5
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && last_op == 2'd1 && $past(level) == '0) |-> status);
endmodule

bind stk_calc stk_calc_chk #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .done(done), .status(status), .res_data(res_data),
  .level(level)
);

// File: tb/sim_stk_calc.sv
module sim_stk_calc;
  localparam int W     = 16;
  localparam int DEPTH = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [1:0]   cmd_op = 2'd0;
  logic [W-1:0] cmd_data = '0;
  logic [W-1:0] res_data;
  logic         done;
  logic         status;

  typedef struct {
    logic         st;
    logic [W-1:0] res;
    int           when;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  logic [W-1:0] mdl[$];
  int checks = 0;
  int errors = 0;
  int pc = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) pc <= pc + 1;

  stk_calc #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .res_data(res_data),
    .done(done), .status(status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: builds the expected item from a software stack model.
  task automatic send(input logic [1:0] op, input logic [W-1:0] d, input string tag);
    exp_t e;
    logic [W-1:0] a, b;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    e.tag = tag; e.when = pc + 2; e.st = 1'b0; e.res = '0;
    case (op)
      2'd0: if (mdl.size() == DEPTH) e.st = 1'b1;
            else begin mdl.push_back(d); e.res = d; end
      2'd1: if (mdl.size() == 0) e.st = 1'b1;
            else e.res = mdl.pop_back();
      default: if (mdl.size() < 2) e.st = 1'b1;
            else begin
              b = mdl.pop_back(); a = mdl.pop_back();
              e.res = (op == 2'd2) ? W'(a + b) : W'(a * b);
              mdl.push_back(e.res);
            end
    endcase
    sb.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, {"R9 ready low after accept ", tag}, cmd_ready, 0);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) chk(1'b0, "R9 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(pc == e.when, {"R9 done timing ", e.tag}, pc, e.when);
        chk(status == e.st, {"status ", e.tag}, status, e.st);
        chk(res_data == e.res, {"result ", e.tag}, res_data, e.res);
      end
    end
  end

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk(cmd_ready == 1'b1, "R10 ready", cmd_ready, 1);
    chk(done == 1'b0, "R10 done", done, 0);
    chk(status == 1'b0, "R10 status", status, 0);
    chk(res_data == '0, "R10 result", res_data, 0);

    send(2'd0, 16'd5, "R2 push");
    send(2'd0, 16'd7, "R2 push");
    send(2'd2, 16'd0, "R6 add");
    send(2'd1, 16'd0, "R4 pop");
    send(2'd1, 16'd0, "R5 pop empty");
    send(2'd2, 16'd0, "R8 add empty");
    send(2'd0, 16'd3, "R2 push");
    send(2'd3, 16'd0, "R8 mul one entry");
    send(2'd1, 16'd0, "R8 entry intact");

    send(2'd0, 16'd3, "R11 A");
    send(2'd0, 16'd4, "R11 B");
    send(2'd2, 16'd0, "R11 add");
    send(2'd0, 16'd5, "R11 C");
    send(2'd0, 16'd6, "R11 D");
    send(2'd2, 16'd0, "R11 add");
    send(2'd3, 16'd0, "R11 mul");
    send(2'd1, 16'd0, "R11 result");

    send(2'd0, 16'hFFFF, "R6 wrap a");
    send(2'd0, 16'd2, "R6 wrap b");
    send(2'd2, 16'd0, "R6 wrap sum");
    send(2'd1, 16'd0, "R6 wrap pop");
    send(2'd0, 16'd300, "R7 a");
    send(2'd0, 16'd300, "R7 b");
    send(2'd3, 16'd0, "R7 truncated product");
    send(2'd1, 16'd0, "R7 pop");

    send(2'd0, 16'd10, "R1 fill");
    send(2'd0, 16'd20, "R1 fill");
    send(2'd0, 16'd30, "R1 fill");
    send(2'd0, 16'd40, "R1 fill");
    send(2'd0, 16'd50, "R3 push full");
    send(2'd1, 16'd0, "R1 R3 pop 40");
    send(2'd1, 16'd0, "R1 pop 30");
    send(2'd1, 16'd0, "R1 pop 20");
    send(2'd1, 16'd0, "R1 pop 10");
    send(2'd1, 16'd0, "R5 pop after drain");
    drain();
    chk(sb.size() == 0, "R9 every command completed", sb.size(), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule